// File: doc/BRIEF.md
# Serial Configuration Register Slave with Burst Load

This block is the configuration port of a larger device. A host drives a three-wire serial link made of a shift clock, a data line and a frame strobe. The block holds five configuration registers, each with its own fixed length, and presents their live values on parallel outputs to the logic they control. A frame opens when the strobe goes low. It carries a direction bit, a test bit and a three-bit address, and then data. Write data is collected in shadow storage while the frame is open. It moves into the live registers only when the strobe rises, so every register written in one frame changes on the same clock.

A write frame may continue past the end of the first register. The data for the next address follows at once, with no gap, and each register takes exactly its own number of bits. A read frame returns the addressed register on the data output, starting at the falling edge that follows the address bits. After reset a busy window discards all commits. Writing a 1 to the soft reset bit of the control word at address 0 returns every register to its default value.

All three serial inputs are synchronised into the system clock domain and edge-detected there. The serial rate must therefore stay well below the system clock rate.

Top module: `serial_cfg_slave`

## Requirements
- R1: A frame is, in order: a direction bit (0 = write, 1 = read), a test bit, the address bits A0, A1, A2, then data with bit 0 first. SDI is sampled on rising SCK edges while SL is low.
- R2: The register lengths and reset values are fixed. Address 0 has 11 bits and resets to 0x000. Address 1 has 10 bits and resets to 0x096. Address 2 has 8 bits and resets to 0x080. Address 3 has 10 bits and resets to 0x000. Address 4 has 6 bits and resets to 0x000.
- R3: Written data stays in shadow storage. The register outputs do not change until SL rises. At that point, every register completed in the frame updates in the same clock cycle.
- R4: In a write frame, the bits that follow the last bit of one register are loaded into the register at the next address. Each register takes exactly its own length.
- R5: Data bits that arrive after address 4 has been filled are ignored. They do not wrap to address 0.
- R6: A register whose full length was not received before SL rises keeps its old value.
- R7: In a read frame, SDO carries bit 0 of the addressed register from the 5th falling SCK edge. It moves to the next bit on each later falling edge. SDO_EN is high while SDO is driven. SDO_EN is low whenever SL is high.
- R8: For BUSY_CYCLES clock cycles after reset is released, no write takes effect.
- R9: When a commit loads address 0 with bit 4 set to 1, all five registers return to their reset values. This overrides any other data in the same frame, and address 0 itself reads 0x000 afterwards.
- R10: A frame whose test bit is 1 writes nothing, and it does not drive SDO_EN.
- R11: SCK edges that occur while SL is high shift nothing into the block, and the next frame starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial shift clock |
| sl | input | 1 | Frame strobe: low while a frame is open, rising edge commits |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial readback data |
| sdo_en | output | 1 | High while sdo is driven |
| reg_op | output | 11 | Address 0, operating control word |
| reg_gain | output | 10 | Address 1, gain word |
| reg_clamp | output | 8 | Address 2, level word |
| reg_ctrl | output | 10 | Address 3, control word |
| reg_cds | output | 6 | Address 4, front-end gain word |

## Verification
The bench builds the block with BUSY_CYCLES set to 400. This is short enough that a complete write frame can be sent and committed inside the window, and the bench then shows that the outputs stay at their reset values. The remaining parameters keep their defaults. The default counter width of 6 bits covers a full burst across all five registers plus the overrun bits, so the bench can reach wrap-free overrun, partial loads and soft reset within a few tens of frames. The serial half period is 8 system clocks, which leaves room for the input synchronisers. SDO is sampled half an SCK period after each falling edge.

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave #(
  parameter int BUSY_CYCLES = 20000,
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        sl,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_en,
  output logic [10:0] reg_op,
  output logic [9:0]  reg_gain,
  output logic [7:0]  reg_clamp,
  output logic [9:0]  reg_ctrl,
  output logic [5:0]  reg_cds
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam int NREG = 5;

  function automatic logic [3:0] last_bit(input logic [2:0] a);
    case (a)
      3'd0: return 4'd10;
      3'd1: return 4'd9;
      3'd2: return 4'd7;
      3'd3: return 4'd9;
      default: return 4'd5;
    endcase
  endfunction

  function automatic logic [10:0] dflt(input int a);
    case (a)
      1: return 11'h096;
      2: return 11'h080;
      default: return 11'h000;
    endcase
  endfunction

  logic [2:0] sck_q, sl_q;
  logic [1:0] sdi_q;
  logic [BW-1:0] busy_cnt;
  logic [CNT_W-1:0] cnt;
  logic rnw, bad;
  logic [2:0] addr;
  logic [3:0] idx;
  logic [10:0] shd [NREG];
  logic [10:0] live [NREG];
  logic [NREG-1:0] ld;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire sl_hi    = sl_q[1];
  wire sl_rise  = sl_q[1] & ~sl_q[2];
  wire din      = sdi_q[1];
  wire busy     = busy_cnt != '0;
  wire [CNT_W-1:0] rbit = cnt - CNT_W'(5);
  wire [10:0] rd_word = (addr < 3'd5) ? live[addr] : 11'h000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      sl_q <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      sl_q <= {sl_q[1:0], sl};
      sdi_q <= {sdi_q[0], sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_cnt <= BW'(BUSY_CYCLES);
    else if (busy) busy_cnt <= busy_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      rnw <= 1'b0;
      bad <= 1'b0;
      addr <= '0;
      idx <= '0;
      ld <= '0;
      for (int i = 0; i < NREG; i++) shd[i] <= '0;
    end else if (sl_hi) begin
      cnt <= '0;
      rnw <= 1'b0;
      bad <= 1'b0;
      addr <= '0;
      idx <= '0;
      ld <= '0;
    end else if (sck_rise) begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      case (cnt)
        CNT_W'(0): rnw <= din;
        CNT_W'(1): bad <= din;
        CNT_W'(2), CNT_W'(3), CNT_W'(4): addr <= {din, addr[2:1]};
        default:
          if (!rnw && !bad && addr < 3'd5) begin
            shd[addr][idx] <= din;
            if (idx == last_bit(addr)) begin
              ld[addr] <= 1'b1;
              addr <= addr + 1'b1;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) live[i] <= dflt(i);
    end else if (sl_rise && !busy) begin
      if (ld[0] && shd[0][4]) begin
        for (int i = 0; i < NREG; i++) live[i] <= dflt(i);
      end else begin
        for (int i = 0; i < NREG; i++)
          if (ld[i]) live[i] <= shd[i];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sdo <= 1'b0;
      sdo_en <= 1'b0;
    end else if (sl_hi) begin
      sdo <= 1'b0;
      sdo_en <= 1'b0;
    end else if (sck_fall && rnw && !bad && cnt >= CNT_W'(5)) begin
      sdo_en <= 1'b1;
      sdo <= (rbit < CNT_W'(11)) ? rd_word[rbit[3:0]] : 1'b0;
    end

  assign reg_op    = live[0];
  assign reg_gain  = live[1][9:0];
  assign reg_clamp = live[2][7:0];
  assign reg_ctrl  = live[3][9:0];
  assign reg_cds   = live[4][5:0];
endmodule

// File: rtl/serial_cfg_slave_chk.sv
module serial_cfg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sl_rise,
  input logic        sl_hi,
  input logic        busy,
  input logic        ld0,
  input logic        rst_bit,
  input logic        sdo_en,
  input logic [10:0] reg_op,
  input logic [9:0]  reg_gain,
  input logic [7:0]  reg_clamp,
  input logic [9:0]  reg_ctrl,
  input logic [5:0]  reg_cds
);
  wire [44:0] all_regs = {reg_op, reg_gain, reg_clamp, reg_ctrl, reg_cds};

  p_hold_until_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sl_rise |=> $stable(all_regs));

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(all_regs));

  p_busy_stays_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_rise && !busy && ld0 && rst_bit) |=>
      (all_regs == {11'h000, 10'h096, 8'h80, 10'h000, 6'h00}));

  p_sdo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sl_hi |=> !sdo_en);
endmodule

bind serial_cfg_slave serial_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sl_rise(sl_rise), .sl_hi(sl_hi), .busy(busy),
  .ld0(ld[0]), .rst_bit(shd[0][4]), .sdo_en(sdo_en),
  .reg_op(reg_op), .reg_gain(reg_gain), .reg_clamp(reg_clamp),
  .reg_ctrl(reg_ctrl), .reg_cds(reg_cds)
);

// File: tb/serial_cfg_slave_tb.sv
`timescale 1ns/100ps
module serial_cfg_slave_tb;
  localparam int HALF = 40;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sl = 1'b1, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [10:0] reg_op;
  logic [9:0] reg_gain, reg_ctrl;
  logic [7:0] reg_clamp;
  logic [5:0] reg_cds;
  int checks = 0, fails = 0;
  bit done = 0;

  serial_cfg_slave #(.BUSY_CYCLES(400)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sl(sl), .sdi(sdi), .sdo(sdo),
    .sdo_en(sdo_en), .reg_op(reg_op), .reg_gain(reg_gain),
    .reg_clamp(reg_clamp), .reg_ctrl(reg_ctrl), .reg_cds(reg_cds));

  always #2.5 clk = ~clk;

  function automatic int len_of(input int a);
    case (a) 0: return 11; 1: return 10; 2: return 8; 3: return 10; default: return 6; endcase
  endfunction

  function automatic logic [10:0] dflt_of(input int a);
    case (a) 1: return 11'h096; 2: return 11'h080; default: return 11'h000; endcase
  endfunction

  function automatic logic [10:0] port_of(input int a);
    case (a)
      0: return reg_op;
      1: return {1'b0, reg_gain};
      2: return {3'b0, reg_clamp};
      3: return {1'b0, reg_ctrl};
      default: return {5'b0, reg_cds};
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b; #HALF; sck = 1'b1; #HALF; sck = 1'b0;
  endtask
  task automatic open_frame(); sl = 1'b0; #HALF; endtask
  task automatic close_frame(); #HALF; sl = 1'b1; #(2*HALF); endtask
  task automatic hdr(input logic rnw, input logic tst, input logic [2:0] a);
    send_bit(rnw); send_bit(tst);
    for (int i = 0; i < 3; i++) send_bit(a[i]);
  endtask
  task automatic data(input logic [10:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask
  task automatic write1(input int a, input logic [10:0] v);
    open_frame(); hdr(1'b0, 1'b0, 3'(a)); data(v, len_of(a)); close_frame();
  endtask
  task automatic read1(input int a, input logic tst, output logic [10:0] v, output logic en_all);
    open_frame(); hdr(1'b1, tst, 3'(a));
    v = '0; en_all = 1'b1;
    for (int k = 0; k < len_of(a); k++) begin
      #HALF; v[k] = sdo; en_all = en_all & sdo_en;
      sck = 1'b1; #HALF; sck = 1'b0;
    end
    close_frame();
  endtask

  localparam logic [15:0] VEC [6] = '{
    {1'b0, 3'd1, 1'b0, 11'h3FF}, {1'b0, 3'd2, 1'b0, 11'h05A},
    {1'b0, 3'd3, 1'b0, 11'h155}, {1'b0, 3'd4, 1'b0, 11'h02A},
    {1'b0, 3'd0, 1'b0, 11'h60F}, {1'b0, 3'd1, 1'b0, 11'h201}};

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [10:0] rv;
    logic en;
    #21 rst_n = 1'b1;
    #10;
    for (int a = 0; a < 5; a++) check("R2 reset value", port_of(a), dflt_of(a));

    write1(1, 11'h123);
    check("R8 write in busy window", port_of(1), 11'h096);
    #3000;

    for (int i = 0; i < 6; i++) begin
      int a;
      logic [10:0] v, m;
      a = int'(VEC[i][14:12]);
      v = VEC[i][10:0];
      m = 11'((1 << len_of(a)) - 1);
      write1(a, v);
      check("R1 single write", port_of(a), v & m);
      read1(a, 1'b0, rv, en);
      check("R7 readback", rv, v & m);
      check("R7 sdo_en during read", {10'b0, en}, 11'd1);
    end
    check("R7 sdo_en off after frame", {10'b0, sdo_en}, 11'd0);

    open_frame(); hdr(1'b0, 1'b0, 3'd1);
    data(11'h2C3, 10); data(11'h07E, 8); data(11'h201, 10);
    check("R3 gain staged", port_of(1), 11'h201);
    check("R3 ctrl staged", port_of(3), 11'h155);
    close_frame();
    check("R4 burst gain", port_of(1), 11'h2C3);
    check("R4 burst clamp", port_of(2), 11'h07E);
    check("R4 burst ctrl", port_of(3), 11'h201);

    open_frame(); hdr(1'b0, 1'b0, 3'd3);
    data(11'h0F0, 10); data(11'h015, 6); data(11'h0FF, 8);
    close_frame();
    check("R5 ctrl", port_of(3), 11'h0F0);
    check("R5 cds", port_of(4), 11'h015);
    check("R5 no wrap to op", port_of(0), 11'h60F);

    open_frame(); hdr(1'b0, 1'b0, 3'd2); data(11'h00F, 5); close_frame();
    check("R6 partial clamp kept", port_of(2), 11'h07E);

    open_frame(); hdr(1'b0, 1'b1, 3'd2); data(11'h011, 8); close_frame();
    check("R10 test bit write ignored", port_of(2), 11'h07E);
    read1(2, 1'b1, rv, en);
    check("R10 test bit read not driven", {10'b0, en}, 11'd0);

    sl = 1'b1;
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    check("R11 sdo_en while SL high", {10'b0, sdo_en}, 11'd0);
    write1(2, 11'h033);
    check("R11 clean frame after idle clocks", port_of(2), 11'h033);

    open_frame(); hdr(1'b0, 1'b0, 3'd0); data(11'h010, 11); data(11'h3FF, 10); close_frame();
    for (int a = 0; a < 5; a++) check("R9 soft reset", port_of(a), dflt_of(a));
    read1(0, 1'b0, rv, en);
    check("R9 op reads zero", rv, 11'h000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule